// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel for a processor's peripheral space. Software writes an 8-bit control byte that selects one of six output behaviours, binary or decimal (BCD) counting and a byte-access format. It then writes the initial count one or two bytes at a time. The counter advances on counter-clock events. These arrive as single-cycle `cnt_tick` strobes that are synchronous to `clk`. A `gate` input can suspend, restart or trigger counting, depending on the behaviour selected. The channel drives one output line.

The six behaviours are as follows:

- Mode 0: an interrupt-on-terminal-count output.
- Mode 1: a gate-triggered, retriggerable one-shot.
- Mode 2: a rate generator.
- Mode 3: a square-wave generator.
- Mode 4: a strobe started by software.
- Mode 5: a strobe started by hardware.

The live count can be read back byte-wise. It can also be frozen by a latch command and read later while counting continues.

The register port carries no stream traffic and has no back-pressure. A write or a read strobe is accepted in the cycle it is presented, and `rd_data` is valid combinationally before the read strobe that consumes it.

Top module: `pit_channel`

## Requirements
- R1: A control byte has this layout: access format in bits [5:4], mode in bits [3:1] and BCD select in bit [0]. Bits [7:6] are ignored. Mode codes 6 and 7 act as modes 2 and 3. A control byte with access format other than 00 sets the output low for mode 0 and high for every other mode, and stops counting until a count is written. After reset, the output is low.
- R2: Access format 01 writes the low byte only, with the high byte taken as zero. Format 10 writes the high byte only, with the low byte zero. Format 11 writes the low byte and then the high byte. A count becomes complete only after its last byte. In modes 0, 2, 3 and 4, a completed count enters the counter on the first tick after the write, and that tick does not decrement.
- R3: In binary mode the counter steps down modulo 65536, and in BCD mode modulo 10000 with decimal digits. A count of zero therefore lasts 65536 or 10000 ticks.
- R4: Mode 0: the output is low after the count is loaded. It rises on the N-th tick after the loading tick and stays high.
- R5: Mode 1: the output stays high until a gate rising edge. The next tick loads the count and drives the output low. The output rises N ticks later. A new gate rising edge before then reloads the count and keeps the output low.
- R6: Mode 2: with count N ≥ 2, the output is low for exactly one tick in every N ticks. The low tick is the (N-1)-th tick of each period.
- R7: Mode 3: the output is high for ceil(N/2) ticks and then low for floor(N/2) ticks, repeating. With N = 1 the output stays high.
- R8: Mode 4: after the loading tick, the output goes low on the N-th tick for exactly one tick. It then stays high.
- R9: Mode 5: a gate rising edge arms the channel, and the next tick loads the count. The output then goes low on the N-th tick for exactly one tick.
- R10: In modes 0, 2, 3 and 4, ticks with the gate low neither decrement the count nor advance the output. In modes 2 and 3, a low gate forces the output high on the next clock.
- R11: In modes 2 and 3, a gate rising edge restarts the period: the next tick reloads the count with the output high.
- R12: A control byte with access format 00 latches the current value, and later reads return the latched value until all bytes of the access format have been read. Without a latch, reads return the live value. For mode 3 the value read is the remaining ticks of the current half period. With format 11, reads alternate low byte and then high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ctrl | input | 1 | 1: write is a control byte; 0: write is a count byte |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe; advances the read byte pointer |
| rd_data | output | 8 | Byte selected for reading |
| cnt_tick | input | 1 | Counter-clock event, one `clk` cycle wide |
| gate | input | 1 | Gate input |
| cnt_out | output | 1 | Channel output |

## Verification
The bench builds the channel at its only width, 16 bits, and keeps counts small. This lets it sweep every mode over each count from 1 (2 for the rate generator) to 10 and check every tick against closed-form waveform formulas. BCD counts of 10 to 25, the aliased mode codes, and both halves of odd and even square waves are covered in the same sweep. The zero-count wrap, the byte-access formats, the latch behaviour and the gate suspend, force and restart cases are reached through readback of values computed arithmetically in the bench.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_t;

  // codes 6 and 7 fold onto 2 and 3
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction

  function automatic ctrl_t decode_ctrl(input logic [5:0] b);
    ctrl_t c;
    c.acc  = acc_e'(b[5:4]);
    c.mode = norm_mode(b[3:1]);
    c.bcd  = b[0];
    return c;
  endfunction
endpackage

// File: rtl/pit_bcd_step.sv
module pit_bcd_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         bcd,
  output logic [W-1:0] nxt
);
  localparam int DIG = W / 4;

  logic [W-1:0]   dec_bcd;
  logic [DIG-1:0] brw;

  assign brw[0] = 1'b1;

  for (genvar i = 0; i < DIG; i++) begin : g_dig
    logic [3:0] d;
    assign d = cur[4*i +: 4];
    assign dec_bcd[4*i +: 4] = brw[i] ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
    if (i < DIG - 1) begin : g_chain
      assign brw[i+1] = brw[i] & (d == 4'd0);
    end
    always_comb begin
      if (!$isunknown({bcd, cur}) && bcd && (d <= 4'd9)) begin
        assert_bcd_digit_R3: assert (dec_bcd[4*i +: 4] <= 4'd9);
      end
    end
  end

  assign nxt = bcd ? dec_bcd : (cur - W'(1));
endmodule

// File: rtl/pit_span.sv
module pit_span #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic         bcd,
  output logic [W:0]   span
);
  localparam int DIG = W / 4;

  function automatic logic [W:0] pow10(input int n);
    logic [W:0] p;
    p = (W+1)'(1);
    for (int k = 0; k < n; k++) p = (p << 3) + (p << 1);
    return p;
  endfunction

  localparam logic [W:0] BCD_FULL = pow10(DIG);
  localparam logic [W:0] BIN_FULL = {1'b1, {W{1'b0}}};

  logic [W:0] acc;

  always_comb begin
    acc = '0;
    for (int i = DIG - 1; i >= 0; i--) begin
      acc = (acc << 3) + (acc << 1) + (W+1)'(cnt[4*i +: 4]);
    end
    if (bcd) span = (acc == '0) ? BCD_FULL : acc;
    else     span = (cnt == '0) ? BIN_FULL : {1'b0, cnt};
  end
endmodule

// File: rtl/pit_host_if.sv
module pit_host_if
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  live_val,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic              ctrl_wr,
  output logic [2:0]        new_mode,
  output logic              cnt_done,
  output logic [CNT_W-1:0]  cnt_reg,
  output logic [BYTE_W-1:0] rd_data
);
  ctrl_t             cfg;
  ctrl_t             cmd;
  logic              wr_hi;
  logic              rd_hi;
  logic              latched;
  logic [BYTE_W-1:0] lo_stage;
  logic [CNT_W-1:0]  latch_val;
  logic [CNT_W-1:0]  rd_src;
  logic              latch_cmd;
  logic              cnt_wr;

  assign cmd       = decode_ctrl(wr_data[5:0]);
  assign ctrl_wr   = wr_en & wr_ctrl & (cmd.acc != ACC_LATCH);
  assign latch_cmd = wr_en & wr_ctrl & (cmd.acc == ACC_LATCH);
  assign cnt_wr    = wr_en & ~wr_ctrl;
  assign cnt_done  = cnt_wr & ((cfg.acc != ACC_BOTH) | wr_hi);
  assign new_mode  = cmd.mode;
  assign mode      = cfg.mode;
  assign bcd       = cfg.bcd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '{acc: ACC_BOTH, mode: 3'd0, bcd: 1'b0};
      wr_hi     <= 1'b0;
      rd_hi     <= 1'b0;
      latched   <= 1'b0;
      lo_stage  <= '0;
      latch_val <= '0;
      cnt_reg   <= '0;
    end else if (ctrl_wr) begin
      cfg     <= cmd;
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (latch_cmd && !latched) begin
        latch_val <= live_val;
        latched   <= 1'b1;
      end
      if (cnt_wr) begin
        case (cfg.acc)
          ACC_HI:   cnt_reg <= {wr_data, {BYTE_W{1'b0}}};
          ACC_BOTH: begin
            if (!wr_hi) begin
              lo_stage <= wr_data;
              wr_hi    <= 1'b1;
            end else begin
              cnt_reg <= {wr_data, lo_stage};
              wr_hi   <= 1'b0;
            end
          end
          default:  cnt_reg <= {{BYTE_W{1'b0}}, wr_data};
        endcase
      end
      if (rd_en) begin
        if (cfg.acc == ACC_BOTH) rd_hi <= ~rd_hi;
        if (latched && ((cfg.acc != ACC_BOTH) || rd_hi)) latched <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_src = latched ? latch_val : live_val;
    case (cfg.acc)
      ACC_HI:   rd_data = rd_src[CNT_W-1:BYTE_W];
      ACC_BOTH: rd_data = rd_hi ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
      default:  rd_data = rd_src[BYTE_W-1:0];
    endcase
  end

  // a held latch keeps its value until it is read out or reprogrammed
  assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !rd_en && !ctrl_wr) |=> ($stable(latch_val) && latched));
endmodule

// File: rtl/pit_core.sv
module pit_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  logic [2:0]   mode,
  input  logic         bcd,
  input  logic [W-1:0] cnt_reg,
  input  logic         ctrl_wr,
  input  logic [2:0]   new_mode,
  input  logic         cnt_done,
  output logic         out,
  output logic [W-1:0] live_val
);
  logic [W-1:0] ce;
  logic [W-1:0] ce_nxt;
  logic [W-1:0] hc;
  logic [W:0]   span;
  logic [W-1:0] half_hi;
  logic [W-1:0] half_lo;
  logic         out_q;
  logic         load_pend;
  logic         trig_pend;
  logic         running;
  logic         spent;
  logic         gate_q;
  logic         gate_rise;
  logic         gated_mode;

  pit_bcd_step #(.W(W)) u_step (.cur(ce), .bcd(bcd), .nxt(ce_nxt));
  pit_span     #(.W(W)) u_span (.cnt(cnt_reg), .bcd(bcd), .span(span));

  assign half_lo    = span[W:1];
  assign half_hi    = span[W:1] + W'(span[0]);
  assign gate_rise  = gate & ~gate_q;
  assign gated_mode = (mode == 3'd2) || (mode == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce <= '0; hc <= '0; out_q <= 1'b0; load_pend <= 1'b0;
      trig_pend <= 1'b0; running <= 1'b0; spent <= 1'b0; gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (ctrl_wr) begin
        out_q     <= (new_mode != 3'd0);
        load_pend <= 1'b0;
        trig_pend <= 1'b0;
        running   <= 1'b0;
        spent     <= 1'b1;
      end else begin
        if (cnt_done) begin
          load_pend <= 1'b1;
          if (mode == 3'd0) out_q <= 1'b0;
        end
        if (gate_rise) trig_pend <= 1'b1;
        if (tick) begin
          case (mode)
            3'd0, 3'd4: begin
              trig_pend <= 1'b0;
              if (load_pend) begin
                ce <= cnt_reg; load_pend <= 1'b0; running <= 1'b1; spent <= 1'b0;
                if (mode == 3'd4) out_q <= 1'b1;
              end else begin
                if (mode == 3'd4 && !out_q) out_q <= 1'b1;
                if (running && gate) begin
                  ce <= ce_nxt;
                  if (ce_nxt == '0) begin
                    if (mode == 3'd0) out_q <= 1'b1;
                    else if (!spent) begin out_q <= 1'b0; spent <= 1'b1; end
                  end
                end
              end
            end
            3'd1, 3'd5: begin
              load_pend <= 1'b0;
              if (trig_pend) begin
                ce <= cnt_reg; trig_pend <= 1'b0; running <= 1'b1; spent <= 1'b0;
                out_q <= (mode == 3'd5);
              end else begin
                if (mode == 3'd5 && !out_q) out_q <= 1'b1;
                if (running) begin
                  ce <= ce_nxt;
                  if (ce_nxt == '0) begin
                    if (mode == 3'd1) out_q <= 1'b1;
                    else if (!spent) begin out_q <= 1'b0; spent <= 1'b1; end
                  end
                end
              end
            end
            default: begin
              if (load_pend || trig_pend) begin
                ce <= cnt_reg; hc <= half_hi; out_q <= 1'b1; running <= 1'b1;
                load_pend <= 1'b0; trig_pend <= 1'b0;
              end else if (running && gate) begin
                if (mode == 3'd2) begin
                  if (ce == W'(1)) begin
                    out_q <= 1'b1;
                    ce    <= cnt_reg;
                  end else begin
                    if (ce == W'(2)) out_q <= 1'b0;
                    ce <= ce_nxt;
                  end
                end else begin
                  if (hc == W'(1)) begin
                    if (out_q) begin
                      if (half_lo == '0) hc <= half_hi;
                      else begin out_q <= 1'b0; hc <= half_lo; end
                    end else begin
                      out_q <= 1'b1;
                      hc    <= half_hi;
                    end
                  end else begin
                    hc <= hc - W'(1);
                  end
                end
              end
            end
          endcase
        end
        if (!gate && gated_mode) out_q <= 1'b1;
      end
    end
  end

  assign out      = out_q;
  assign live_val = (mode == 3'd3) ? hc : ce;

  assert_ctrl_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (out_q == ($past(new_mode) != 3'd0)));

  assert_m0_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && out_q && !ctrl_wr && !cnt_done) |=> out_q);

  assert_gate_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && !gate && !ctrl_wr) |=> out_q);

  assert_gate_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate && (mode == 3'd0 || mode == 3'd4) && !load_pend && !ctrl_wr)
      |=> $stable(ce));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              cnt_tick,
  input  logic              gate,
  output logic              cnt_out
);
  logic [2:0]       mode;
  logic             bcd;
  logic             ctrl_wr;
  logic [2:0]       new_mode;
  logic             cnt_done;
  logic [CNT_W-1:0] cnt_reg;
  logic [CNT_W-1:0] live_val;

  pit_host_if u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .rd_en(rd_en), .live_val(live_val), .mode(mode), .bcd(bcd), .ctrl_wr(ctrl_wr),
    .new_mode(new_mode), .cnt_done(cnt_done), .cnt_reg(cnt_reg), .rd_data(rd_data)
  );

  pit_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .gate(gate), .mode(mode), .bcd(bcd),
    .cnt_reg(cnt_reg), .ctrl_wr(ctrl_wr), .new_mode(new_mode), .cnt_done(cnt_done),
    .out(cnt_out), .live_val(live_val)
  );
endmodule

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       cnt_tick = 1'b0;
  logic       gate = 1'b1;
  logic       cnt_out;
  int         n_run = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  pit_channel u_pit_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .cnt_tick(cnt_tick), .gate(gate), .cnt_out(cnt_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put_ctrl(input int acc, input int md, input int bc);
    wr_en = 1'b1; wr_ctrl = 1'b1; wr_data = 8'((acc << 4) | (md << 1) | bc);
    @(negedge clk);
    wr_en = 1'b0; wr_ctrl = 1'b0;
  endtask

  task automatic put_cnt(input int b);
    wr_en = 1'b1; wr_ctrl = 1'b0; wr_data = 8'(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic sg(input bit v);
    gate = v;
    @(negedge clk);
  endtask

  task automatic rd(output int b);
    b = int'(rd_data);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 1000 % 10) << 12) | ((v / 100 % 10) << 8) | ((v / 10 % 10) << 4) | (v % 10);
  endfunction

  function automatic string mode_tag(input int em);
    case (em)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // one full programming sequence with per-tick expectations
  task automatic run_mode(input int m, input int n, input int bc);
    int    em;
    int    val;
    int    lim;
    int    e;
    string tag;
    em  = (m >= 6) ? m - 4 : m;
    val = bc ? to_bcd(n) : n;
    tag = bc ? "R3" : mode_tag(em);
    put_ctrl(3, m, bc);
    chk("R1 level after control byte", int'(cnt_out), (em == 0) ? 0 : 1);
    put_cnt(val & 255);
    put_cnt(val >> 8);
    if (em == 1 || em == 5) begin
      tk();
      chk("R5/R9 idle before trigger", int'(cnt_out), 1);
      sg(1'b0);
      sg(1'b1);
    end
    tk();
    chk("R2 level after loading tick", int'(cnt_out), (em == 0 || em == 1) ? 0 : 1);
    lim = (em == 2 || em == 3) ? 3 * n : 2 * n;
    for (int k = 1; k <= lim; k++) begin
      tk();
      case (em)
        0, 1:    e = (k >= n) ? 1 : 0;
        2:       e = ((k % n) == n - 1) ? 0 : 1;
        3:       e = ((k % n) < (n + 1) / 2) ? 1 : 0;
        default: e = (k == n) ? 0 : 1;
      endcase
      chk(tag, int'(cnt_out), e);
    end
  endtask

  initial begin : main
    int lo;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset output", int'(cnt_out), 0);
    chk("R12 reset readback", int'(rd_data), 0);

    for (int m = 0; m < 6; m++)
      for (int n = (m == 2) ? 2 : 1; n <= 10; n++) run_mode(m, n, 0);
    run_mode(6, 5, 0);
    run_mode(7, 6, 0);
    run_mode(7, 7, 0);
    for (int i = 0; i < 4; i++) begin
      int nb;
      nb = (i == 3) ? 25 : 10 + i;
      run_mode(0, nb, 1);
      run_mode(3, nb, 1);
      run_mode(2, nb, 1);
    end

    // R2: half-written word does not load
    put_ctrl(3, 0, 0);
    put_cnt(2);
    tk(); tk(); tk();
    chk("R2 no load before high byte", int'(cnt_out), 0);
    put_cnt(0);
    tk(); tk();
    chk("R2 one tick short", int'(cnt_out), 0);
    tk();
    chk("R2 terminal after full write", int'(cnt_out), 1);

    // R2: low-only format
    put_ctrl(1, 0, 0);
    put_cnt(5);
    tk(); tk();
    rd(lo);
    chk("R2 low-only readback", lo, 4);
    tk(); tk(); tk();
    chk("R2 low-only before terminal", int'(cnt_out), 0);
    tk();
    chk("R2 low-only terminal", int'(cnt_out), 1);

    // R2: high-only format
    put_ctrl(2, 0, 0);
    put_cnt(1);
    tk();
    rd(hi);
    chk("R2 high-only loaded", hi, 1);
    tk();
    rd(hi);
    chk("R2 high-only after one tick", hi, 0);

    // R3: zero counts wrap to the top
    put_ctrl(3, 0, 0);
    put_cnt(0); put_cnt(0);
    tk(); tk();
    rd(lo); rd(hi);
    chk("R3 binary zero wrap", (hi << 8) | lo, 16'hFFFF);
    put_ctrl(3, 0, 1);
    put_cnt(0); put_cnt(0);
    tk(); tk();
    rd(lo); rd(hi);
    chk("R3 bcd zero wrap", (hi << 8) | lo, 16'h9999);
    put_ctrl(3, 0, 1);
    put_cnt(0); put_cnt(1);
    tk(); tk();
    rd(lo); rd(hi);
    chk("R3 bcd borrow", (hi << 8) | lo, 16'h0099);

    // R12: latch then keep counting
    put_ctrl(3, 0, 0);
    put_cnt(8'h23); put_cnt(8'h01);
    tk();
    repeat (5) tk();
    put_ctrl(0, 0, 0);
    tk(); tk(); tk();
    rd(lo); rd(hi);
    chk("R12 latched value", (hi << 8) | lo, 16'h011E);
    rd(lo); rd(hi);
    chk("R12 live value after latch read", (hi << 8) | lo, 16'h011B);

    // R10: mode 0 suspended by low gate
    put_ctrl(3, 0, 0);
    put_cnt(3); put_cnt(0);
    tk(); tk();
    sg(1'b0);
    repeat (4) tk();
    chk("R10 mode 0 held while gate low", int'(cnt_out), 0);
    sg(1'b1);
    tk();
    chk("R10 mode 0 resumes", int'(cnt_out), 0);
    tk();
    chk("R10 mode 0 terminal after resume", int'(cnt_out), 1);

    // R10/R11: mode 2 gate forcing and restart
    put_ctrl(3, 2, 0);
    put_cnt(4); put_cnt(0);
    tk();
    tk(); tk(); tk();
    chk("R6 low tick before gate test", int'(cnt_out), 0);
    sg(1'b0);
    chk("R10 low gate forces high", int'(cnt_out), 1);
    tk(); tk();
    rd(lo); rd(hi);
    chk("R10 count frozen with gate low", (hi << 8) | lo, 1);
    sg(1'b1);
    tk();
    rd(lo); rd(hi);
    chk("R11 gate rise reloads", (hi << 8) | lo, 4);
    tk(); tk();
    chk("R11 high after restart", int'(cnt_out), 1);
    tk();
    chk("R11 low tick after restart", int'(cnt_out), 0);

    // R5: retrigger extends the one-shot
    put_ctrl(3, 1, 0);
    put_cnt(4); put_cnt(0);
    sg(1'b0); sg(1'b1);
    tk(); tk(); tk();
    sg(1'b0); sg(1'b1);
    tk();
    tk(); tk(); tk();
    chk("R5 retrigger keeps output low", int'(cnt_out), 0);
    tk();
    chk("R5 retriggered terminal", int'(cnt_out), 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule